// File: doc/BRIEF.md
# Boot-Block Map and Lock Protection

This block sits between the command decoder and the program/erase sequencer of a 19-bit word-addressed flash array. It maps a word address onto one of 19 erase blocks of unequal size: one 8-kword boot block, two 4-kword parameter blocks, one 16-kword main block and fifteen 32-kword main blocks. An elaboration parameter picks the layout. In the top-boot layout the small blocks sit at the high end of the address space. In the bottom-boot layout they sit mirrored at the low end.

The block keeps one lock flag per erase block. A flag value of 1 means the block may be modified and 0 means it is locked. The flags are held in flops that take a parameterised value at reset. For each program or erase request, the block decides whether the operation may proceed and returns a one-cycle grant or a one-cycle error pulse.

The protection is bypassed when either of two inputs is high: a write-protect release input, or a digital flag that stands in for the high-voltage override. An erase granted under bypass returns the erased block's flag to 1. A lock command clears the flag of the addressed block. The flag of the addressed block can be read on bit 6 of a status byte.

Top module: `boot_lock_guard`

## Requirements
- R1: With TOP_BOOT=1, word addresses 00000h–77FFFh map to block address[18:15] (0–14); 78000h–7BFFFh map to 15; 7C000h–7CFFFh map to 16; 7D000h–7DFFFh map to 17; 7E000h–7FFFFh map to 18. The mapping is combinational on blk_o.
- R2: With TOP_BOOT=0, 00000h–01FFFh map to 0; 02000h–02FFFh map to 1; 03000h–03FFFh map to 2; 04000h–07FFFh map to 3; from 08000h upward each 32-kword block maps to address[18:15]+3 (4–18).
- R3: While rst_ni is low, every lock flag takes the value LOCK_RST, which defaults to 0 (locked). While rst_ni is low, all grant and error outputs are 0.
- R4: A cycle with lock_set_i high clears the lock flag of the addressed block at the next clock edge and leaves every other flag unchanged. In the same cycle, lock_set_i wins over the unlock caused by an erase.
- R5: When wp_i=0, hv_ovr_i=0 and the addressed block's flag is 0, a program or erase request is refused. The matching error output pulses high for exactly the one cycle after the request, the matching grant output stays 0, and the flag is not changed.
- R6: When wp_i=1 or hv_ovr_i=1, a program or erase request is granted whatever the flag value. The matching grant output pulses high for the one cycle after the request.
- R7: When the addressed block's flag is 1, a request is granted even with wp_i=0 and hv_ovr_i=0.
- R8: An erase granted while wp_i or hv_ovr_i is high sets the erased block's flag to 1. A program request never changes any flag.
- R9: lock_dq_o carries the addressed block's flag on bit 6. All of its other bits are 0.
- R10: The grant and error outputs are 0 in any cycle that does not follow a matching request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 19 | Word address of the operation or lock query |
| wp_i | input | 1 | Write-protect release; 1 bypasses the lock flags |
| hv_ovr_i | input | 1 | High-voltage override flag; 1 bypasses the lock flags |
| pgm_req_i | input | 1 | Program request for the addressed block (one cycle) |
| ers_req_i | input | 1 | Erase request for the addressed block (one cycle) |
| lock_set_i | input | 1 | Lock the addressed block (clear its flag) |
| blk_o | output | 5 | Decoded block index |
| lock_dq_o | output | 8 | Lock status byte; bit 6 is the flag |
| pgm_ok_o | output | 1 | Program granted (registered pulse) |
| pgm_err_o | output | 1 | Program refused (registered pulse) |
| ers_ok_o | output | 1 | Erase granted (registered pulse) |
| ers_err_o | output | 1 | Erase refused (registered pulse) |

## Verification
The assertions check on every cycle how each request relates to its response. A refused request on a locked block yields an error pulse. A bypassed or unlocked request yields a grant. No response appears without a request. The flag moves as lock commands and bypassed erases demand, and the status byte never carries stray bits.

Only the bench's scenarios can show that the decoder matches the intended layout. For that, the bench sweeps every address of both the top-boot and the bottom-boot variant. The scenarios also show that a lock on one block leaves its neighbours alone, and that lock and erase in the same cycle resolve in favour of the lock.

// File: rtl/bblk_pkg.sv
package bblk_pkg;
  localparam int NUM_BLK = 19;
  localparam int BLK_W   = $clog2(NUM_BLK);
  typedef logic [BLK_W-1:0] blk_idx_t;
endpackage

// File: rtl/bblk_decode.sv
module bblk_decode
  import bblk_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output blk_idx_t          blk_o
);
  localparam int HI_W   = 4;
  localparam int HI_LSB = ADDR_W - HI_W;
  localparam int B16    = HI_LSB - 1;  // splits the 16-kword half from the small blocks
  localparam int B8     = HI_LSB - 2;  // splits the boot block from the parameter pair
  localparam int B4     = HI_LSB - 3;  // splits the two parameter blocks

  logic [HI_W-1:0] hi;
  assign hi = addr_i[ADDR_W-1:HI_LSB];

  generate
    if (TOP_BOOT) begin : g_top
      always_comb begin
        if (hi != {HI_W{1'b1}})  blk_o = blk_idx_t'(hi);
        else if (!addr_i[B16])   blk_o = blk_idx_t'(15);
        else if (addr_i[B8])     blk_o = blk_idx_t'(18);
        else if (addr_i[B4])     blk_o = blk_idx_t'(17);
        else                     blk_o = blk_idx_t'(16);
      end
    end else begin : g_bot
      always_comb begin
        if (hi != '0)            blk_o = blk_idx_t'(hi) + blk_idx_t'(3);
        else if (addr_i[B16])    blk_o = blk_idx_t'(3);
        else if (!addr_i[B8])    blk_o = blk_idx_t'(0);
        else if (addr_i[B4])     blk_o = blk_idx_t'(2);
        else                     blk_o = blk_idx_t'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/bblk_lock_bank.sv
module bblk_lock_bank
  import bblk_pkg::*;
#(
  parameter int NBLK     = NUM_BLK,
  parameter bit LOCK_RST = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            set_i,    // lock: flag -> 0
  input  logic            clr_i,    // unlock after bypassed erase: flag -> 1
  input  blk_idx_t        idx_i,
  output logic [NBLK-1:0] lock_o
);
  for (genvar g = 0; g < NBLK; g++) begin : g_flag
    logic hit;
    assign hit = (idx_i == blk_idx_t'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             lock_o[g] <= LOCK_RST;
      else if (set_i && hit)   lock_o[g] <= 1'b0;
      else if (clr_i && hit)   lock_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/bblk_guard.sv
module bblk_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_bit_i,
  input  logic wp_i,
  input  logic hv_i,
  input  logic pgm_req_i,
  input  logic ers_req_i,
  output logic unlock_o,
  output logic pgm_ok_o,
  output logic pgm_err_o,
  output logic ers_ok_o,
  output logic ers_err_o
);
  logic bypass, allow;
  assign bypass   = wp_i | hv_i;
  assign allow    = bypass | lock_bit_i;
  assign unlock_o = ers_req_i & bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_ok_o  <= 1'b0;
      pgm_err_o <= 1'b0;
      ers_ok_o  <= 1'b0;
      ers_err_o <= 1'b0;
    end else begin
      pgm_ok_o  <= pgm_req_i &  allow;
      pgm_err_o <= pgm_req_i & ~allow;
      ers_ok_o  <= ers_req_i &  allow;
      ers_err_o <= ers_req_i & ~allow;
    end
  end
endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
  import bblk_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter bit TOP_BOOT = 1'b1,
  parameter bit LOCK_RST = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_i,
  input  logic              hv_ovr_i,
  input  logic              pgm_req_i,
  input  logic              ers_req_i,
  input  logic              lock_set_i,
  output logic [BLK_W-1:0]  blk_o,
  output logic [7:0]        lock_dq_o,
  output logic              pgm_ok_o,
  output logic              pgm_err_o,
  output logic              ers_ok_o,
  output logic              ers_err_o
);
  localparam int STAT_BIT = 6;

  blk_idx_t           blk;
  logic [NUM_BLK-1:0] lock_q;
  logic               lock_bit, unlock;

  bblk_decode #(.ADDR_W(ADDR_W), .TOP_BOOT(TOP_BOOT)) u_dec (
    .addr_i (addr_i),
    .blk_o  (blk)
  );

  bblk_lock_bank #(.NBLK(NUM_BLK), .LOCK_RST(LOCK_RST)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (lock_set_i),
    .clr_i  (unlock),
    .idx_i  (blk),
    .lock_o (lock_q)
  );

  assign lock_bit = lock_q[blk];

  bblk_guard u_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_bit_i (lock_bit),
    .wp_i       (wp_i),
    .hv_i       (hv_ovr_i),
    .pgm_req_i  (pgm_req_i),
    .ers_req_i  (ers_req_i),
    .unlock_o   (unlock),
    .pgm_ok_o   (pgm_ok_o),
    .pgm_err_o  (pgm_err_o),
    .ers_ok_o   (ers_ok_o),
    .ers_err_o  (ers_err_o)
  );

  assign blk_o = blk;
  always_comb begin
    lock_dq_o           = '0;
    lock_dq_o[STAT_BIT] = lock_bit;
  end
endmodule

// File: rtl/bblk_lock_chk.sv
module bblk_lock_chk
  import bblk_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wp_i,
  input logic               hv_ovr_i,
  input logic               pgm_req_i,
  input logic               ers_req_i,
  input logic               lock_set_i,
  input logic [BLK_W-1:0]   blk_o,
  input logic [7:0]         lock_dq_o,
  input logic [NUM_BLK-1:0] lock_q,
  input logic               pgm_ok_o,
  input logic               pgm_err_o,
  input logic               ers_ok_o,
  input logic               ers_err_o
);
  AST_BLK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_o < BLK_W'(NUM_BLK)); // R1

  AST_PGM_LOCKED_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_i && !wp_i && !hv_ovr_i && !lock_dq_o[6] |=> pgm_err_o && !pgm_ok_o); // R5

  AST_ERS_LOCKED_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_req_i && !wp_i && !hv_ovr_i && !lock_dq_o[6] |=> ers_err_o && !ers_ok_o); // R5

  AST_BYPASS_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_req_i || ers_req_i) && (wp_i || hv_ovr_i)
      |=> (pgm_ok_o || !$past(pgm_req_i)) && (ers_ok_o || !$past(ers_req_i))); // R6

  AST_UNLOCKED_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_i && lock_dq_o[6] |=> pgm_ok_o && !pgm_err_o); // R7

  AST_SET_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_set_i |=> !lock_q[$past(blk_o)]); // R4

  AST_ERASE_UNLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ers_req_i && (wp_i || hv_ovr_i) && !lock_set_i |=> lock_q[$past(blk_o)]); // R8

  AST_NO_SPURIOUS_PGM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_req_i |=> !pgm_ok_o && !pgm_err_o); // R10

  AST_NO_SPURIOUS_ERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ers_req_i |=> !ers_ok_o && !ers_err_o); // R10

  always_comb begin
    if (rst_ni) AST_STATUS_CLEAN: assert ((lock_dq_o & 8'hBF) == 8'h00); // R9
  end
endmodule

bind boot_lock_guard bblk_lock_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wp_i       (wp_i),
  .hv_ovr_i   (hv_ovr_i),
  .pgm_req_i  (pgm_req_i),
  .ers_req_i  (ers_req_i),
  .lock_set_i (lock_set_i),
  .blk_o      (blk_o),
  .lock_dq_o  (lock_dq_o),
  .lock_q     (lock_q),
  .pgm_ok_o   (pgm_ok_o),
  .pgm_err_o  (pgm_err_o),
  .ers_ok_o   (ers_ok_o),
  .ers_err_o  (ers_err_o)
);

// File: tb/tb_boot_lock_guard.sv
module tb_boot_lock_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 19;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_ni = 1'b0;
  logic [18:0] addr = '0;
  logic        wp = 1'b0, hv = 1'b0, pgm = 1'b0, ers = 1'b0, lset = 1'b0;
  logic [4:0]  blk_t, blk_b;
  logic [7:0]  dq_t, dq_b;
  logic        pok_t, perr_t, eok_t, eerr_t;
  logic        pok_b, perr_b, eok_b, eerr_b;

  int n_vec = 0;
  int n_bad = 0;

  boot_lock_guard #(.TOP_BOOT(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wp_i(wp), .hv_ovr_i(hv),
    .pgm_req_i(pgm), .ers_req_i(ers), .lock_set_i(lset), .blk_o(blk_t),
    .lock_dq_o(dq_t), .pgm_ok_o(pok_t), .pgm_err_o(perr_t),
    .ers_ok_o(eok_t), .ers_err_o(eerr_t));

  boot_lock_guard #(.TOP_BOOT(1'b0)) dut_bot (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wp_i(wp), .hv_ovr_i(hv),
    .pgm_req_i(pgm), .ers_req_i(ers), .lock_set_i(lset), .blk_o(blk_b),
    .lock_dq_o(dq_b), .pgm_ok_o(pok_b), .pgm_err_o(perr_b),
    .ers_ok_o(eok_b), .ers_err_o(eerr_b));

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_top(int a);
    if (a < 'h78000) return a / 'h8000;
    if (a < 'h7C000) return 15;
    if (a < 'h7D000) return 16;
    if (a < 'h7E000) return 17;
    return 18;
  endfunction

  function automatic int exp_bot(int a);
    if (a < 'h2000) return 0;
    if (a < 'h3000) return 1;
    if (a < 'h4000) return 2;
    if (a < 'h8000) return 3;
    return a / 'h8000 + 3;
  endfunction

  function automatic int base_top(int i);
    if (i < 15) return i * 'h8000;
    case (i)
      15: return 'h78000;
      16: return 'h7C000;
      17: return 'h7D000;
      default: return 'h7E000;
    endcase
  endfunction

  // drive one request cycle from a negedge; return at the next negedge with outputs valid
  task automatic op(int a, bit w, bit h, bit p, bit e, bit s);
    addr = 19'(a); wp = w; hv = h; pgm = p; ers = e; lset = s;
    @(posedge clk);
    @(negedge clk);
    pgm = 1'b0; ers = 1'b0; lset = 1'b0; wp = 1'b0; hv = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R3 pgm_ok in reset", int'(pok_t), 0);
    check("R3 ers_err in reset", int'(eerr_t), 0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R3: all flags locked after reset
    for (int i = 0; i < NB; i++) begin
      addr = 19'(base_top(i) + 'h10); #1;
      check("R3 flag after reset", int'(dq_t), 0);
    end

    // R1 / R2: full address sweep of both layouts
    for (int a = 0; a < (1 << 19); a++) begin
      addr = 19'(a); #1;
      check("R1 top decode", int'(blk_t), exp_top(a));
      check("R2 bottom decode", int'(blk_b), exp_bot(a));
    end
    @(negedge clk);

    // R5: locked blocks refuse both operations, flag unchanged
    for (int i = 0; i < NB; i++) begin
      op(base_top(i) + 'h20, 0, 0, 1, 0, 0);
      check("R5 pgm_err", int'(perr_t), 1);
      check("R5 pgm_ok", int'(pok_t), 0);
      op(base_top(i) + 'h20, 0, 0, 0, 1, 0);
      check("R5 ers_err", int'(eerr_t), 1);
      check("R5 ers_ok", int'(eok_t), 0);
      check("R5 flag kept", int'(dq_t), 0);
      #(CLK_PERIOD);
      check("R10 err pulse ends", int'(eerr_t), 0);
    end

    // R6 / R8: bypassed erase on even blocks (hv), program on odd blocks (wp)
    for (int i = 0; i < NB; i++) begin
      if (i % 2 == 0) begin
        op(base_top(i), 0, 1, 0, 1, 0);
        check("R6 ers_ok under hv", int'(eok_t), 1);
        check("R8 erase unlocks", int'(dq_t), 'h40);
      end else begin
        op(base_top(i), 1, 0, 1, 0, 0);
        check("R6 pgm_ok under wp", int'(pok_t), 1);
        check("R6 pgm_err under wp", int'(perr_t), 0);
        check("R8 program keeps flag", int'(dq_t), 0);
      end
    end

    // R7: unlocked blocks grant without bypass; locked still refuse
    for (int i = 0; i < NB; i++) begin
      op(base_top(i) + 'h40, 0, 0, 1, 0, 0);
      check("R7 pgm_ok by flag", int'(pok_t), (i % 2 == 0) ? 1 : 0);
      check("R7 pgm_err by flag", int'(perr_t), (i % 2 == 0) ? 0 : 1);
      check("R9 status byte", int'(dq_t), (i % 2 == 0) ? 'h40 : 0);
    end
    op(base_top(2), 0, 0, 0, 1, 0);
    check("R7 ers_ok by flag", int'(eok_t), 1);
    check("R7 flag stays set", int'(dq_t), 'h40);

    // R8: erase under wp releases an odd block
    op(base_top(1), 1, 0, 0, 1, 0);
    check("R8 wp erase ok", int'(eok_t), 1);
    check("R8 wp erase unlocks", int'(dq_t), 'h40);

    // R4: lock block 4, neighbours untouched
    op(base_top(4), 0, 0, 0, 0, 1);
    check("R4 lock set", int'(dq_t), 0);
    addr = 19'(base_top(2)); #1;
    check("R4 neighbour 2", int'(dq_t), 'h40);
    addr = 19'(base_top(6)); #1;
    check("R4 neighbour 6", int'(dq_t), 'h40);
    @(negedge clk);
    op(base_top(4), 0, 0, 1, 0, 0);
    check("R4 locked refuses", int'(perr_t), 1);

    // R4: lock and bypassed erase together -> lock wins, erase still granted
    op(base_top(8), 0, 1, 0, 1, 1);
    check("R4 erase granted", int'(eok_t), 1);
    check("R4 lock priority", int'(dq_t), 0);

    // R10: idle cycle has no responses
    #(CLK_PERIOD);
    check("R10 idle pgm", int'(pok_t | perr_t), 0);
    check("R10 idle ers", int'(eok_t | eerr_t), 0);

    // R9: status byte on boot block (unlocked, even index 18)
    addr = 19'('h7FFFF); #1;
    check("R9 boot block status", int'(dq_t), 'h40);

    summary();
    $finish;
  end
endmodule